// File: doc/BRIEF.md
# ADC Test Pattern Generator

This block sits between a 14-bit converter core and its capture interface. On every sample enable it puts one word on the output. The word is either the live converter sample or a known test pattern, chosen by a 4-bit mode input. The patterns are fixed levels, a checkerboard, a word toggle, two pseudo-random streams, a ramp, and user-supplied words. A receiver can then check the whole capture path against values it can predict.

Each pseudo-random stream has its own reseed strobe, so either can be brought back to its start without disturbing the other. User patterns take two programmable words and a 2-bit submode. The submode picks between steady repetition, continuous alternation, and one-shot variants that go quiet after they finish. Any change of the mode or submode value counts as a new selection: the ramp, the alternation phase and the one-shot progress all begin again.

Top module: `adc_pattern_gen`

## Requirements
- R1: While `rstN` is low, `dataOut` is 0 and `dataValid` is 0. Both pseudo-random registers are seeded to all ones.
- R2: A cycle with `sampleEn` high makes `dataValid` high in the next cycle, with the new word on `dataOut`. A cycle with `sampleEn` low makes `dataValid` low in the next cycle, and `dataOut` keeps its value.
- R3: Mode 4'b0000 passes `normData` to the output. Each unlisted code from 4'b1001 to 4'b1110 does the same.
- R4: Mode 4'b0001 outputs 14'h2000. Mode 4'b0010 outputs 14'h3FFF. Mode 4'b0011 outputs 14'h0000.
- R5: Mode 4'b0100 outputs 14'h2AAA on the first sample after selection, then 14'h1555, and keeps alternating between the two.
- R6: Mode 4'b0111 outputs 14'h3FFF on the first sample after selection, then 14'h0000, and keeps alternating between the two.
- R7: Mode 4'b0101 takes 14 steps of a 23-bit register per sample. Each step forms the bit s[22]^s[17] and shifts it into s[0]. The word holds the 14 new bits, with the first one generated in bit 13. The register advances only on samples taken in this mode.
- R8: Mode 4'b0110 works the same way on a 9-bit register whose feedback bit is s[8]^s[4].
- R9: A high `pnLongRst` reseeds the 23-bit register to all ones, and a high `pnShortRst` reseeds the 9-bit register to all ones. A reseed wins over a step in the same cycle. Each strobe leaves the other register untouched.
- R10: Mode 4'b1111 outputs 0 on the first sample after selection. It adds one on each later sample and wraps from 14'h3FFF to 0.
- R11: Mode 4'b1000 with `userSub` 2'b00 outputs `userWordA` on every sample. With 2'b01 it outputs `userWordA` and `userWordB` in turn, starting with A.
- R12: Mode 4'b1000 with `userSub` 2'b10 outputs `userWordA` once. With 2'b11 it outputs `userWordA` and then `userWordB`. After that, both submodes output 0 until the selection changes.
- R13: Any change of `modeSel` or `userSub` starts a new selection. This holds even on cycles with no sample. A sample taken in the cycle of the change is the first sample of the new selection.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| sampleEn | input | 1 | Produce one output word this cycle |
| normData | input | 14 | Live converter sample |
| modeSel | input | 4 | Pattern mode select |
| userSub | input | 2 | User pattern submode |
| userWordA | input | 14 | First user pattern word |
| userWordB | input | 14 | Second user pattern word |
| pnLongRst | input | 1 | Reseed the 23-bit pseudo-random register |
| pnShortRst | input | 1 | Reseed the 9-bit pseudo-random register |
| dataOut | output | 14 | Output word |
| dataValid | output | 1 | Output word updated in this cycle |

## Verification
Every result shows up exactly one clock after the edge that took the sample. This covers the pattern word, the valid flag, and the held word after an idle cycle. Sequence effects such as the alternation phase, the ramp count, the one-shot progress and the pseudo-random advance appear at that same edge for each sample. The bench drives inputs on the falling edge and lets one rising edge take the sample. It reads `dataOut` and `dataValid` on the next falling edge. Reseed strobes and selection changes are applied in cycles with no sample, so the word they affect is the first one sampled afterwards.

// File: rtl/apg_pkg.sv
package apg_pkg;

  typedef enum logic [3:0] {
    PK_PASS,
    PK_MID,
    PK_POSFS,
    PK_NEGFS,
    PK_CHECKER,
    PK_PNLONG,
    PK_PNSHORT,
    PK_TOGGLE,
    PK_USER,
    PK_RAMP
  } patKind_t;

  typedef enum logic [1:0] {
    UP_A,
    UP_B,
    UP_ZERO
  } userPick_t;

  typedef struct packed {
    patKind_t  kind;
    logic      restart;
    logic      take;
    logic      altPhase;
    userPick_t pick;
    logic      stepLong;
    logic      stepShort;
  } apgStrobe_t;

endpackage

// File: rtl/apg_lfsr.sv
module apg_lfsr #(
  parameter int LEN  = 23,
  parameter int TAP  = 18,
  parameter int OUTW = 14
) (
  input  logic            clk,
  input  logic            rstN,
  input  logic            seed,
  input  logic            step,
  output logic [OUTW-1:0] word
);

  logic [LEN-1:0] stateQ;
  logic [LEN-1:0] stateNext;

  // Run OUTW serial steps; the first bit produced lands in the word's MSB.
  always_comb begin
    logic [LEN-1:0] s;
    logic           fb;
    s    = stateQ;
    word = '0;
    for (int i = 0; i < OUTW; i++) begin
      fb   = s[LEN-1] ^ s[TAP-1];
      s    = {s[LEN-2:0], fb};
      word = {word[OUTW-2:0], fb};
    end
    stateNext = s;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     stateQ <= '1;
    else if (seed) stateQ <= '1;
    else if (step) stateQ <= stateNext;
  end

endmodule

// File: rtl/apg_ctrl.sv
module apg_ctrl
  import apg_pkg::*;
(
  input  logic       clk,
  input  logic       rstN,
  input  logic       sampleEn,
  input  logic [3:0] modeSel,
  input  logic [1:0] userSub,
  output apgStrobe_t strobes
);

  logic [3:0] modeQ;
  logic [1:0] subQ;
  logic       phaseQ;
  logic [1:0] onceQ;
  logic       cfgChange;
  logic       effPhase;
  logic [1:0] effOnce;
  patKind_t   kind;
  userPick_t  pick;

  assign cfgChange = (modeSel != modeQ) || (userSub != subQ);
  assign effPhase  = cfgChange ? 1'b0 : phaseQ;
  assign effOnce   = cfgChange ? 2'd0 : onceQ;

  always_comb begin
    unique case (modeSel)
      4'b0001: kind = PK_MID;
      4'b0010: kind = PK_POSFS;
      4'b0011: kind = PK_NEGFS;
      4'b0100: kind = PK_CHECKER;
      4'b0101: kind = PK_PNLONG;
      4'b0110: kind = PK_PNSHORT;
      4'b0111: kind = PK_TOGGLE;
      4'b1000: kind = PK_USER;
      4'b1111: kind = PK_RAMP;
      default: kind = PK_PASS;
    endcase
  end

  always_comb begin
    unique case (userSub)
      2'b00:   pick = UP_A;
      2'b01:   pick = effPhase ? UP_B : UP_A;
      2'b10:   pick = (effOnce == 2'd0) ? UP_A : UP_ZERO;
      default: pick = (effOnce == 2'd0) ? UP_A :
                      (effOnce == 2'd1) ? UP_B : UP_ZERO;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      modeQ  <= '0;
      subQ   <= '0;
      phaseQ <= 1'b0;
      onceQ  <= '0;
    end else begin
      modeQ  <= modeSel;
      subQ   <= userSub;
      phaseQ <= sampleEn ? ~effPhase : effPhase;
      onceQ  <= (sampleEn && effOnce != 2'd2) ? effOnce + 2'd1 : effOnce;
    end
  end

  always_comb begin
    strobes.kind      = kind;
    strobes.restart   = cfgChange;
    strobes.take      = sampleEn;
    strobes.altPhase  = effPhase;
    strobes.pick      = pick;
    strobes.stepLong  = sampleEn && (kind == PK_PNLONG);
    strobes.stepShort = sampleEn && (kind == PK_PNSHORT);
  end

endmodule

// File: rtl/apg_datapath.sv
module apg_datapath
  import apg_pkg::*;
#(
  parameter int DW        = 14,
  parameter int LONG_LEN  = 23,
  parameter int LONG_TAP  = 18,
  parameter int SHORT_LEN = 9,
  parameter int SHORT_TAP = 5
) (
  input  logic          clk,
  input  logic          rstN,
  input  apgStrobe_t    strobes,
  input  logic [DW-1:0] normData,
  input  logic [DW-1:0] userWordA,
  input  logic [DW-1:0] userWordB,
  input  logic          pnLongRst,
  input  logic          pnShortRst,
  output logic [DW-1:0] dataOut,
  output logic          dataValid
);

  localparam logic [DW-1:0] MIDSCALE = {1'b1, {(DW-1){1'b0}}};
  localparam logic [DW-1:0] FULL     = '1;
  localparam logic [DW-1:0] ZERO     = '0;

  logic [DW-1:0] chkOdd;
  logic [DW-1:0] rampQ;
  logic [DW-1:0] effRamp;
  logic [DW-1:0] longWord;
  logic [DW-1:0] shortWord;
  logic [DW-1:0] userWord;
  logic [DW-1:0] nextWord;

  always_comb begin
    for (int i = 0; i < DW; i++) chkOdd[i] = ((i % 2) == 1);
  end

  apg_lfsr #(.LEN(LONG_LEN), .TAP(LONG_TAP), .OUTW(DW)) longGen_i (
    .clk  (clk),
    .rstN (rstN),
    .seed (pnLongRst),
    .step (strobes.stepLong),
    .word (longWord)
  );

  apg_lfsr #(.LEN(SHORT_LEN), .TAP(SHORT_TAP), .OUTW(DW)) shortGen_i (
    .clk  (clk),
    .rstN (rstN),
    .seed (pnShortRst),
    .step (strobes.stepShort),
    .word (shortWord)
  );

  assign effRamp = strobes.restart ? ZERO : rampQ;

  always_comb begin
    unique case (strobes.pick)
      UP_A:    userWord = userWordA;
      UP_B:    userWord = userWordB;
      default: userWord = ZERO;
    endcase
  end

  always_comb begin
    unique case (strobes.kind)
      PK_MID:     nextWord = MIDSCALE;
      PK_POSFS:   nextWord = FULL;
      PK_NEGFS:   nextWord = ZERO;
      PK_CHECKER: nextWord = strobes.altPhase ? ~chkOdd : chkOdd;
      PK_PNLONG:  nextWord = longWord;
      PK_PNSHORT: nextWord = shortWord;
      PK_TOGGLE:  nextWord = strobes.altPhase ? ZERO : FULL;
      PK_USER:    nextWord = userWord;
      PK_RAMP:    nextWord = effRamp;
      default:    nextWord = normData;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      rampQ     <= '0;
      dataOut   <= '0;
      dataValid <= 1'b0;
    end else begin
      rampQ     <= (strobes.take && strobes.kind == PK_RAMP) ? effRamp + 1'b1 : effRamp;
      dataValid <= strobes.take;
      if (strobes.take) dataOut <= nextWord;
    end
  end

endmodule

// File: rtl/adc_pattern_gen.sv
module adc_pattern_gen
  import apg_pkg::*;
#(
  parameter int DW = 14
) (
  input  logic          clk,
  input  logic          rstN,
  input  logic          sampleEn,
  input  logic [DW-1:0] normData,
  input  logic [3:0]    modeSel,
  input  logic [1:0]    userSub,
  input  logic [DW-1:0] userWordA,
  input  logic [DW-1:0] userWordB,
  input  logic          pnLongRst,
  input  logic          pnShortRst,
  output logic [DW-1:0] dataOut,
  output logic          dataValid
);

  apgStrobe_t strobes;

  apg_ctrl ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .sampleEn (sampleEn),
    .modeSel  (modeSel),
    .userSub  (userSub),
    .strobes  (strobes)
  );

  apg_datapath #(.DW(DW)) dp_i (
    .clk        (clk),
    .rstN       (rstN),
    .strobes    (strobes),
    .normData   (normData),
    .userWordA  (userWordA),
    .userWordB  (userWordB),
    .pnLongRst  (pnLongRst),
    .pnShortRst (pnShortRst),
    .dataOut    (dataOut),
    .dataValid  (dataValid)
  );

endmodule

// File: rtl/apg_checker.sv
module apg_checker #(
  parameter int DW = 14
) (
  input logic          clk,
  input logic          rstN,
  input logic          sampleEn,
  input logic [DW-1:0] normData,
  input logic [3:0]    modeSel,
  input logic [DW-1:0] dataOut,
  input logic          dataValid
);

  localparam logic [DW-1:0] FULL   = '1;
  localparam logic [DW-1:0] CHK_HI = 14'h2AAA;
  localparam logic [DW-1:0] CHK_LO = 14'h1555;

  a_r2_valid_follows: assert property (@(posedge clk) disable iff (!rstN)
    sampleEn |=> dataValid);

  a_r2_idle_hold: assert property (@(posedge clk) disable iff (!rstN)
    !sampleEn |=> (!dataValid && $stable(dataOut)));

  a_r3_passthrough: assert property (@(posedge clk) disable iff (!rstN)
    (sampleEn && (modeSel == 4'b0000 || (modeSel >= 4'b1001 && modeSel <= 4'b1110)))
      |=> dataOut == $past(normData));

  a_r4_midscale: assert property (@(posedge clk) disable iff (!rstN)
    (sampleEn && modeSel == 4'b0001) |=> dataOut == 14'h2000);

  a_r4_fullscale: assert property (@(posedge clk) disable iff (!rstN)
    (sampleEn && modeSel == 4'b0010) |=> dataOut == FULL);

  a_r5_checker_values: assert property (@(posedge clk) disable iff (!rstN)
    (sampleEn && modeSel == 4'b0100) |=> (dataOut == CHK_HI || dataOut == CHK_LO));

  a_r6_toggle_values: assert property (@(posedge clk) disable iff (!rstN)
    (sampleEn && modeSel == 4'b0111) |=> (dataOut == FULL || dataOut == '0));

endmodule

bind adc_pattern_gen apg_checker #(.DW(DW)) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .sampleEn  (sampleEn),
  .normData  (normData),
  .modeSel   (modeSel),
  .dataOut   (dataOut),
  .dataValid (dataValid)
);

// File: tb/adc_pattern_gen_tb.sv
`timescale 1ns/1ps
module adc_pattern_gen_tb_top;

  logic        clk = 1'b0;
  logic        rstN;
  logic        sampleEn;
  logic [13:0] normData;
  logic [3:0]  modeSel;
  logic [1:0]  userSub;
  logic [13:0] userWordA;
  logic [13:0] userWordB;
  logic        pnLongRst;
  logic        pnShortRst;
  logic [13:0] dataOut;
  logic        dataValid;

  int  checks = 0;
  int  fails  = 0;
  bit  ended  = 0;
  logic [22:0] longS;
  logic [22:0] shortS;

  always #2 clk = ~clk;

  adc_pattern_gen dut_i (
    .clk(clk), .rstN(rstN), .sampleEn(sampleEn), .normData(normData),
    .modeSel(modeSel), .userSub(userSub), .userWordA(userWordA),
    .userWordB(userWordB), .pnLongRst(pnLongRst), .pnShortRst(pnShortRst),
    .dataOut(dataOut), .dataValid(dataValid)
  );

  task automatic chk(input string req, input logic [13:0] act, input logic [13:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // One sample: drive on the falling edge, result due one rising edge later.
  task automatic takeSample(input logic [13:0] exp, input string req);
    sampleEn = 1'b1;
    @(posedge clk);
    @(negedge clk);
    chk(req, dataOut, exp);
    chk({req, " valid"}, {13'd0, dataValid}, 14'd1);
  endtask

  task automatic idle(input int n);
    sampleEn = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [13:0] pnWord(input int len, input int tap, inout logic [22:0] s);
    logic [13:0] w;
    logic        b;
    logic [22:0] mask;
    mask = 23'h7FFFFF >> (23 - len);
    w = '0;
    for (int i = 0; i < 14; i++) begin
      b = s[len-1] ^ s[tap-1];
      s = ((s << 1) | {22'd0, b}) & mask;
      w = {w[12:0], b};
    end
    return w;
  endfunction

  task automatic finishRun();
    if (!ended) begin
      ended = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  endtask

  task automatic tReset();
    chk("R1 out", dataOut, 14'd0);
    chk("R1 valid", {13'd0, dataValid}, 14'd0);
  endtask

  task automatic tPass();
    logic [13:0] d;
    modeSel = 4'b0000;
    d = 14'h1234; normData = d; takeSample(d, "R3 mode0");
    d = 14'h3ABC; normData = d; takeSample(d, "R3 mode0");
    modeSel = 4'b1001; d = 14'h0F0F; normData = d; takeSample(d, "R3 mode9");
    modeSel = 4'b1110; d = 14'h2001; normData = d; takeSample(d, "R3 mode14");
    idle(1);
    chk("R2 idle valid", {13'd0, dataValid}, 14'd0);
    normData = 14'h0777;
    idle(2);
    chk("R2 idle hold", dataOut, 14'h2001);
  endtask

  task automatic tConst();
    modeSel = 4'b0001; takeSample(14'h2000, "R4 mid");
    modeSel = 4'b0010; takeSample(14'h3FFF, "R4 posfs");
    modeSel = 4'b0011; takeSample(14'h0000, "R4 negfs");
  endtask

  task automatic tChecker();
    modeSel = 4'b0100;
    for (int i = 0; i < 5; i++) takeSample((i % 2 == 0) ? 14'h2AAA : 14'h1555, "R5 checker");
    idle(2);
    modeSel = 4'b0111;
    for (int i = 0; i < 5; i++) takeSample((i % 2 == 0) ? 14'h3FFF : 14'h0000, "R6 toggle");
    idle(1);
  endtask

  task automatic tPn();
    longS = 23'h7FFFFF; shortS = 23'h1FF;
    modeSel = 4'b0101;
    for (int i = 0; i < 4; i++) takeSample(pnWord(23, 18, longS), "R7 pn long");
    modeSel = 4'b1111;
    takeSample(14'd0, "R10 ramp interlude");
    modeSel = 4'b0101;
    takeSample(pnWord(23, 18, longS), "R7 pn long resumes");
    modeSel = 4'b0110;
    for (int i = 0; i < 6; i++) takeSample(pnWord(9, 5, shortS), "R8 pn short");
    idle(1);
    pnShortRst = 1'b1; @(negedge clk); pnShortRst = 1'b0;
    shortS = 23'h1FF;
    takeSample(pnWord(9, 5, shortS), "R9 short reseed");
    modeSel = 4'b0101;
    takeSample(pnWord(23, 18, longS), "R9 long unaffected");
    idle(1);
    pnLongRst = 1'b1; @(negedge clk); pnLongRst = 1'b0;
    longS = 23'h7FFFFF;
    takeSample(pnWord(23, 18, longS), "R9 long reseed");
    modeSel = 4'b0110;
    takeSample(pnWord(9, 5, shortS), "R9 short unaffected");
    idle(1);
  endtask

  task automatic tRamp();
    modeSel = 4'b1111;
    for (int i = 0; i < 16386; i++) takeSample(14'(i), "R10 ramp");
    idle(1);
    modeSel = 4'b0001; idle(1);
    modeSel = 4'b1111;
    takeSample(14'd0, "R13 ramp restart");
    takeSample(14'd1, "R10 ramp step");
    idle(1);
  endtask

  task automatic tUser();
    userWordA = 14'h0ABC; userWordB = 14'h3123;
    modeSel = 4'b1000; userSub = 2'b00;
    for (int i = 0; i < 3; i++) takeSample(14'h0ABC, "R11 repeat");
    userSub = 2'b01;
    for (int i = 0; i < 4; i++) takeSample((i % 2 == 0) ? 14'h0ABC : 14'h3123, "R11 alternate");
    userSub = 2'b10;
    takeSample(14'h0ABC, "R12 once A");
    takeSample(14'h0000, "R12 once done");
    takeSample(14'h0000, "R12 once done");
    userSub = 2'b11;
    takeSample(14'h0ABC, "R12 alt once A");
    takeSample(14'h3123, "R12 alt once B");
    takeSample(14'h0000, "R12 alt once done");
    idle(1);
    userSub = 2'b00; idle(1);
    userSub = 2'b11; idle(1);
    takeSample(14'h0ABC, "R13 sub change restarts");
    takeSample(14'h3123, "R13 sub change restarts B");
    idle(1);
  endtask

  initial begin
    #(4 * 200000);
    fails++;
    $display("FAIL watchdog actual=hung expected=done");
    finishRun();
  end

  initial begin
    rstN = 1'b0; sampleEn = 1'b0; normData = '0; modeSel = '0; userSub = '0;
    userWordA = '0; userWordB = '0; pnLongRst = 1'b0; pnShortRst = 1'b0;
    repeat (3) @(negedge clk);
    tReset();
    rstN = 1'b1;
    @(negedge clk);
    tPass();
    tConst();
    tChecker();
    tPn();
    tUser();
    tRamp();
    finishRun();
  end

endmodule